// File: doc/BRIEF.md
# Trace Port Packet Extractor

This block sits behind the capture path of a processor trace port and turns the per-cycle samples into a stream of 8-bit trace packets. Each sample carries a pipeline-status code, a packet field of up to 16 bits, a trigger flag and a synchronisation flag. A sample whose status says the core emitted no trace data, or that carries the trigger flag, contributes nothing. Samples that do carry data are cut or joined according to the configured port width. On a 16-bit port a sample gives two bytes. On an 8-bit port it gives one byte. On a 4-bit port two samples are joined into one byte.

A downstream decoder can ask the block to skip forward. A skip request with a count N throws samples away until the Nth sample marked with the synchronisation flag arrives, and extraction starts with that sample. Samples enter through a valid/ready handshake and leave through another. A stalled output never consumes input. A synchronous flush drops any half-finished byte state. An underflow pulse reports that the consumer wanted a byte when the capture stream had already ended.

Top module: `trace_pkt_extract`

## Requirements
- R1: After reset `m_valid` is 0, `s_ready` is 1 and `underflow` is 0.
- R2: With `port_mode` 2'b01 (or the spare code 2'b11, which acts the same) each data-carrying sample yields one byte equal to `s_data[7:0]`.
- R3: With `port_mode` 2'b10 each data-carrying sample yields two bytes: `s_data[7:0]` first, then `s_data[15:8]`. The sample is released only after the high byte has been produced.
- R4: With `port_mode` 2'b00 one byte is built from two consecutive data-carrying samples as {second `s_data[3:0]`, first `s_data[3:0]`}. A single sample alone never yields a byte.
- R5: A sample whose `s_stat` equals `NODATA_CODE` (default 3'd6), or whose `s_trig` is 1, yields no byte and is discarded.
- R6: In 4-bit mode a discarded sample (R5) also discards a pending low nibble, so the next byte is built from the next two data-carrying samples.
- R7: A one-cycle `skip_go` with `skip_n`=N>0 discards samples until the Nth sample with `s_sync`=1. That sample and the samples after it are extracted normally. `skip_n`=0 leaves extraction unchanged. No byte is produced in the `skip_go` cycle.
- R8: A one-cycle `flush` makes the next 16-bit extraction start at the low byte and drops a pending 4-bit low nibble. No byte is produced in the flush cycle, and a byte already on the output is kept.
- R9: `underflow` is 1 in the cycle after a cycle with `m_ready`=1, `m_valid`=0, no buffered sample, `s_valid`=0 and `s_end`=1. Otherwise it is 0.
- R10: While `m_valid`=1 and `m_ready`=0, `m_valid` and `m_data` hold, and no sample is consumed, so `s_ready` stays 0 once the internal sample slot is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_mode | input | 2 | 00 4-bit, 01 8-bit, 10 16-bit, 11 8-bit |
| flush | input | 1 | Clear half selector and pending nibble |
| skip_go | input | 1 | Load a skip request |
| skip_n | input | SKIP_W | Number of sync-marked samples to reach |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted this cycle when high with s_valid |
| s_stat | input | STAT_W | Pipeline-status code of the sample |
| s_data | input | DATA_W | Raw packet field of the sample |
| s_trig | input | 1 | Trigger flag of the sample |
| s_sync | input | 1 | Synchronisation flag of the sample |
| s_end | input | 1 | Capture stream has ended |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Consumer takes the byte |
| m_data | output | 8 | Output trace byte |
| underflow | output | 1 | Byte wanted after the stream ended |

## Verification
A sample accepted at clock edge k is placed in the slot and processed at edge k+1. Its first byte is therefore visible on `m_data` after edge k+1, and a 16-bit high byte follows one edge after the low byte is taken. `underflow` appears one edge after its qualifying cycle. The bench drives inputs just after rising edges and samples at falling edges. It records every byte that transfers and compares the recorded sequence against an expected sequence built from the requirements after a drain of several cycles. This keeps the byte checks independent of exact latency. Latency-sensitive results are sampled at the exact falling edge that follows the edge where they are due: the stall hold, `s_ready` during stalls, and the underflow pulse.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

   // Port width selection as seen on the port_mode input
   typedef enum logic [1:0] {
      PW_NIB  = 2'b00,
      PW_BYTE = 2'b01,
      PW_HALF = 2'b10,
      PW_ALT  = 2'b11
   } port_mode_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;

endpackage

// File: rtl/tpx_slot.sv
// One-entry sample holding register between the capture side and extraction.
module tpx_slot #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [STAT_W-1:0] in_stat,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_trig,
   input  logic              in_sync,
   input  logic              pop,
   output logic              held,
   output logic [STAT_W-1:0] held_stat,
   output logic [DATA_W-1:0] held_data,
   output logic              held_trig,
   output logic              held_sync
);

   logic vld_q;

   assign in_ready = !vld_q;
   assign held     = vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         held_stat <= '0;
         held_data <= '0;
         held_trig <= 1'b0;
         held_sync <= 1'b0;
      end else if (in_valid && !vld_q) begin
         vld_q     <= 1'b1;
         held_stat <= in_stat;
         held_data <= in_data;
         held_trig <= in_trig;
         held_sync <= in_sync;
      end else if (pop) begin
         vld_q <= 1'b0;
      end
   end

endmodule

// File: rtl/tpx_gate.sv
// Decides whether the held sample is discarded or passed to packing,
// and tracks an outstanding skip-to-sync request.
module tpx_gate #(
   parameter int unsigned           STAT_W      = 3,
   parameter int unsigned           SKIP_W      = 4,
   parameter logic [STAT_W-1:0]     NODATA_CODE = 3'd6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              skip_go,
   input  logic [SKIP_W-1:0] skip_n,
   input  logic              step,
   input  logic              held,
   input  logic [STAT_W-1:0] held_stat,
   input  logic              held_trig,
   input  logic              held_sync,
   output logic              pass,
   output logic              drop
);

   localparam logic [SKIP_W-1:0] LAST_SYNC = SKIP_W'(1);

   logic [SKIP_W-1:0] left_q;
   logic              skipping;
   logic              reach;
   logic              no_data;

   assign skipping = (left_q != '0);
   assign reach    = held_sync && (left_q == LAST_SYNC);
   assign no_data  = (held_stat == NODATA_CODE) || held_trig;
   assign drop     = held && ((skipping && !reach) || no_data);
   assign pass     = held && !drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (skip_go) begin
         left_q <= skip_n;
      end else if (step && held && skipping && held_sync) begin
         left_q <= left_q - LAST_SYNC;
      end
   end

endmodule

// File: rtl/tpx_pack.sv
// Splits or joins sample fields into bytes and owns the output register.
module tpx_pack
   import tpx_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter bit          NIB_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        port_mode,
   input  logic              fire,
   input  logic              pass,
   input  logic              drop,
   input  logic [DATA_W-1:0] data,
   output logic              pop,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [BYTE_W-1:0] m_data
);

   port_mode_e        mode;
   logic              half_q, half_n;
   logic              emit;
   logic [BYTE_W-1:0] byte_n;
   logic              nib_ld, nib_clr;
   logic              nib_vld;
   logic [NIB_W-1:0]  nib_q;

   assign mode = port_mode_e'(port_mode);

   always_comb begin
      emit    = 1'b0;
      pop     = 1'b0;
      byte_n  = '0;
      half_n  = half_q;
      nib_ld  = 1'b0;
      nib_clr = 1'b0;
      if (fire) begin
         if (drop) begin
            pop     = 1'b1;
            half_n  = 1'b0;
            nib_clr = 1'b1;
         end else if (pass) begin
            unique case (mode)
               PW_NIB: begin
                  pop = 1'b1;
                  if (nib_vld) begin
                     emit    = 1'b1;
                     byte_n  = {data[NIB_W-1:0], nib_q};
                     nib_clr = 1'b1;
                  end else begin
                     nib_ld = 1'b1;
                  end
               end
               PW_HALF: begin
                  emit = 1'b1;
                  if (half_q) begin
                     byte_n = data[2*BYTE_W-1:BYTE_W];
                     pop    = 1'b1;
                     half_n = 1'b0;
                  end else begin
                     byte_n = data[BYTE_W-1:0];
                     half_n = 1'b1;
                  end
               end
               default: begin
                  emit   = 1'b1;
                  byte_n = data[BYTE_W-1:0];
                  pop    = 1'b1;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     half_q <= 1'b0;
      else if (flush) half_q <= 1'b0;
      else            half_q <= half_n;
   end

   generate
      if (NIB_EN) begin : g_nib
         logic             nv_q;
         logic [NIB_W-1:0] nd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               nv_q <= 1'b0;
               nd_q <= '0;
            end else if (flush || nib_clr) begin
               nv_q <= 1'b0;
            end else if (nib_ld) begin
               nv_q <= 1'b1;
               nd_q <= data[NIB_W-1:0];
            end
         end
         assign nib_vld = nv_q;
         assign nib_q   = nd_q;
      end else begin : g_no_nib
         assign nib_vld = 1'b0;
         assign nib_q   = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_data  <= '0;
      end else if (emit) begin
         m_valid <= 1'b1;
         m_data  <= byte_n;
      end else if (m_ready) begin
         m_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/trace_pkt_extract.sv
module trace_pkt_extract #(
   parameter int unsigned           DATA_W      = 16,
   parameter int unsigned           STAT_W      = 3,
   parameter int unsigned           SKIP_W      = 4,
   parameter logic [STAT_W-1:0]     NODATA_CODE = 3'd6,
   parameter bit                    NIB_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        port_mode,
   input  logic              flush,
   input  logic              skip_go,
   input  logic [SKIP_W-1:0] skip_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [STAT_W-1:0] s_stat,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_trig,
   input  logic              s_sync,
   input  logic              s_end,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [7:0]        m_data,
   output logic              underflow
);

   generate
      if (DATA_W < 16) begin : g_bad_data_w
         $error("trace_pkt_extract: DATA_W must be at least 16");
      end
      if (SKIP_W < 1) begin : g_bad_skip_w
         $error("trace_pkt_extract: SKIP_W must be at least 1");
      end
      if (STAT_W < 1) begin : g_bad_stat_w
         $error("trace_pkt_extract: STAT_W must be at least 1");
      end
   endgenerate

   logic              held, held_trig, held_sync;
   logic [STAT_W-1:0] held_stat;
   logic [DATA_W-1:0] held_data;
   logic              pass, drop, pop, fire, out_free;
   logic              und_q;

   assign out_free  = !m_valid || m_ready;
   assign fire      = held && out_free && !flush && !skip_go;
   assign underflow = und_q;

   tpx_slot #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s_valid),
      .in_ready  (s_ready),
      .in_stat   (s_stat),
      .in_data   (s_data),
      .in_trig   (s_trig),
      .in_sync   (s_sync),
      .pop       (pop),
      .held      (held),
      .held_stat (held_stat),
      .held_data (held_data),
      .held_trig (held_trig),
      .held_sync (held_sync)
   );

   tpx_gate #(.STAT_W(STAT_W), .SKIP_W(SKIP_W), .NODATA_CODE(NODATA_CODE)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .skip_go   (skip_go),
      .skip_n    (skip_n),
      .step      (fire),
      .held      (held),
      .held_stat (held_stat),
      .held_trig (held_trig),
      .held_sync (held_sync),
      .pass      (pass),
      .drop      (drop)
   );

   tpx_pack #(.DATA_W(DATA_W), .NIB_EN(NIB_EN)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .port_mode (port_mode),
      .fire      (fire),
      .pass      (pass),
      .drop      (drop),
      .data      (held_data),
      .pop       (pop),
      .m_valid   (m_valid),
      .m_ready   (m_ready),
      .m_data    (m_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) und_q <= 1'b0;
      else        und_q <= m_ready && !m_valid && !held && !s_valid && s_end;
   end

endmodule

// File: rtl/tpx_checker.sv
module tpx_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       flush,
   input logic       skip_go,
   input logic       s_valid,
   input logic       s_ready,
   input logic       s_end,
   input logic       m_valid,
   input logic       m_ready,
   input logic [7:0] m_data,
   input logic       underflow
);

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data)))
      else $error("stalled output byte changed");

   p_stall_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready && !s_ready) |=> !s_ready)
      else $error("sample slot released during stall");

   p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !m_valid) |=> !m_valid)
      else $error("byte produced in flush cycle");

   p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_go && !m_valid) |=> !m_valid)
      else $error("byte produced in skip request cycle");

   p_underflow_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> ($past(s_end) && $past(m_ready) && !$past(m_valid) && !$past(s_valid)))
      else $error("underflow without an ended stream");

endmodule

bind trace_pkt_extract tpx_checker u_tpx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .skip_go   (skip_go),
   .s_valid   (s_valid),
   .s_ready   (s_ready),
   .s_end     (s_end),
   .m_valid   (m_valid),
   .m_ready   (m_ready),
   .m_data    (m_data),
   .underflow (underflow)
);

// File: tb/trace_pkt_extract_bench.sv
`timescale 1ns/1ps
module trace_pkt_extract_bench;

   localparam logic [2:0] NODATA = 3'd6;
   localparam logic [2:0] EXEC   = 3'd0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  port_mode = 2'b01;
   logic        flush = 1'b0, skip_go = 1'b0;
   logic [3:0]  skip_n = '0;
   logic        s_valid = 1'b0, s_ready;
   logic [2:0]  s_stat = '0;
   logic [15:0] s_data = '0;
   logic        s_trig = 1'b0, s_sync = 1'b0, s_end = 1'b0;
   logic        m_valid, m_ready = 1'b1;
   logic [7:0]  m_data;
   logic        underflow;

   int nchk = 0;
   int nerr = 0;
   logic [7:0] got [$];
   logic [7:0] exp_q [$];

   always #4 clk = ~clk;

   trace_pkt_extract u_trace_pkt_extract (
      .clk(clk), .rst_n(rst_n), .port_mode(port_mode), .flush(flush),
      .skip_go(skip_go), .skip_n(skip_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_stat(s_stat), .s_data(s_data), .s_trig(s_trig), .s_sync(s_sync),
      .s_end(s_end), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
      .underflow(underflow)
   );

   always @(negedge clk) if (rst_n && m_valid && m_ready) got.push_back(m_data);

   task automatic check(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic check_q(input string req);
      check(got.size() == exp_q.size(), {req, " byte count"}, got.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got.size(); i++)
         check(got[i] == exp_q[i], req, got[i], exp_q[i]);
      got.delete();
      exp_q.delete();
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send(input logic [2:0] st, input logic [15:0] d,
                       input logic tg, input logic sy);
      @(posedge clk); #1;
      s_stat = st; s_data = d; s_trig = tg; s_sync = sy; s_valid = 1'b1;
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1;
      s_valid = 1'b0;
   endtask

   task automatic pulse_flush();
      @(posedge clk); #1 flush = 1'b1;
      @(posedge clk); #1 flush = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(m_valid == 1'b0, "R1 m_valid", m_valid, 0);
      check(s_ready == 1'b1, "R1 s_ready", s_ready, 1);
      check(underflow == 1'b0, "R1 underflow", underflow, 0);
   endtask

   task automatic t_byte_mode();
      port_mode = 2'b01;
      send(EXEC, 16'h1234, 0, 0);
      send(EXEC, 16'h5678, 0, 0);
      port_mode = 2'b11;
      send(EXEC, 16'h9ABC, 0, 0);
      tick(4);
      exp_q = '{8'h34, 8'h78, 8'hBC};
      check_q("R2 byte mode");
   endtask

   task automatic t_half_mode();
      port_mode = 2'b10;
      send(EXEC, 16'hA1B2, 0, 0);
      send(EXEC, 16'hC3D4, 0, 0);
      tick(5);
      exp_q = '{8'hB2, 8'hA1, 8'hD4, 8'hC3};
      check_q("R3 half mode");
   endtask

   task automatic t_nib_mode();
      port_mode = 2'b00;
      send(EXEC, 16'h0005, 0, 0);
      send(EXEC, 16'h00FA, 0, 0);
      send(EXEC, 16'h0003, 0, 0);
      send(EXEC, 16'h0FFC, 0, 0);
      tick(4);
      exp_q = '{8'hA5, 8'hC3};
      check_q("R4 nibble mode");
   endtask

   task automatic t_gate();
      port_mode = 2'b01;
      send(NODATA, 16'h0011, 0, 0);
      send(EXEC,   16'h0022, 1, 0);
      send(EXEC,   16'h0033, 0, 0);
      tick(4);
      exp_q = '{8'h33};
      check_q("R5 no-data and trigger gating");
   endtask

   task automatic t_gate_nib();
      port_mode = 2'b00;
      send(EXEC,   16'h0001, 0, 0);
      send(NODATA, 16'h0002, 0, 0);
      send(EXEC,   16'h0003, 0, 0);
      send(EXEC,   16'h0004, 0, 0);
      tick(4);
      exp_q = '{8'h43};
      check_q("R6 gated sample drops nibble");
   endtask

   task automatic t_skip();
      port_mode = 2'b01;
      @(posedge clk); #1 skip_go = 1'b1; skip_n = 4'd2;
      @(posedge clk); #1 skip_go = 1'b0;
      send(EXEC, 16'h0010, 0, 0);
      send(EXEC, 16'h0020, 0, 1);
      send(EXEC, 16'h0030, 0, 0);
      send(EXEC, 16'h0040, 0, 1);
      send(EXEC, 16'h0050, 0, 1);
      tick(4);
      exp_q = '{8'h40, 8'h50};
      check_q("R7 skip to second sync");
      @(posedge clk); #1 skip_go = 1'b1; skip_n = 4'd0;
      @(posedge clk); #1 skip_go = 1'b0;
      send(EXEC, 16'h0060, 0, 0);
      tick(4);
      exp_q = '{8'h60};
      check_q("R7 zero skip count");
   endtask

   task automatic t_flush_half();
      port_mode = 2'b10;
      m_ready = 1'b0;
      send(EXEC, 16'hBEEF, 0, 0);
      tick(3);
      @(negedge clk);
      check(m_valid == 1'b1 && m_data == 8'hEF, "R8 low byte held", m_data, 8'hEF);
      pulse_flush();
      m_ready = 1'b1;
      tick(6);
      exp_q = '{8'hEF, 8'hEF, 8'hBE};
      check_q("R8 flush restarts at low byte");
   endtask

   task automatic t_flush_nib();
      port_mode = 2'b00;
      send(EXEC, 16'h0007, 0, 0);
      tick(3);
      pulse_flush();
      send(EXEC, 16'h0008, 0, 0);
      send(EXEC, 16'h0009, 0, 0);
      tick(4);
      exp_q = '{8'h98};
      check_q("R8 flush drops nibble");
   endtask

   task automatic t_stall();
      port_mode = 2'b01;
      m_ready = 1'b0;
      send(EXEC, 16'h0001, 0, 0);
      send(EXEC, 16'h0002, 0, 0);
      tick(2);
      @(posedge clk); #1 s_stat = EXEC; s_data = 16'h0003; s_valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(s_ready == 1'b0, "R10 no sample taken in stall", s_ready, 0);
         check(m_valid == 1'b1 && m_data == 8'h01, "R10 byte held in stall", m_data, 8'h01);
      end
      s_valid = 1'b0;
      m_ready = 1'b1;
      send(EXEC, 16'h0003, 0, 0);
      tick(4);
      exp_q = '{8'h01, 8'h02, 8'h03};
      check_q("R10 order after stall");
   endtask

   task automatic t_underflow();
      port_mode = 2'b00;
      send(EXEC, 16'h0005, 0, 0);
      tick(3);
      exp_q.delete();
      check_q("R4 lone nibble yields no byte");
      @(negedge clk);
      check(underflow == 1'b0, "R9 no underflow before end", underflow, 0);
      @(posedge clk); #1 s_end = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(underflow == 1'b1, "R9 underflow after end", underflow, 1);
      #1 s_end = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(underflow == 1'b0, "R9 underflow clears", underflow, 0);
      pulse_flush();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      tick(3);
      t_reset();
      @(posedge clk); #1 rst_n = 1'b1;
      tick(2);
      t_reset();
      t_byte_mode();
      t_half_mode();
      t_nib_mode();
      t_gate();
      t_gate_nib();
      t_skip();
      t_flush_half();
      t_flush_nib();
      t_stall();
      t_underflow();
      finish_run();
   end

endmodule